// File: doc/BRIEF.md
# Rectangle Pattern and Expand Blitter

This engine fills a rectangle of destination bytes in video memory, one byte at a time, from a source that also lives in video memory. It supports four source kinds: a plain byte copy, an 8-row colour pattern, colour expansion from a monochrome bitmap, and colour expansion from an 8-row monochrome pattern. Pixels may be 8, 16 or 32 bits wide. In the expand modes, the destination's low address bits select a byte lane of a 32-bit foreground or background colour.

Software loads the configuration ports and pulses `start`. The engine copies the configuration into its own registers and then repeats a pair of memory cycles for every destination byte: a read of the source, pattern or mask byte, followed by a write of the destination byte with a byte enable. When the last byte is written, the engine returns to idle and raises `done`.

Top module: `rect_blit`

## Requirements
- R1: After a synchronous active-low reset, the engine is idle: `done`=0, `mem_we`=0 and `mem_addr`=0.
- R2: In idle, a `start` pulse captures every configuration port. The engine then processes (cfg_width+1)×(cfg_height+1) destination bytes. Each byte takes one read cycle (`mem_we`=0) and then one write cycle (`mem_we`=1). `done` goes to 0 in the first read cycle. It goes to 1 in the cycle after the last write and holds until the next accepted start. A `start` pulse while busy is ignored. The mode field is decoded as follows: bits [1:0] give the pixel width (0 = 8, 1 = 16, 2 = 32 bpp), bit 2 selects backwards, bit 3 selects pattern and bit 4 selects expand.
- R3: Plain copy (pattern=0, expand=0): each byte read from the source is written unchanged with `mem_wmask`=1. The source address steps with the destination address.
- R4: After each byte within a row, the destination address moves by +1, or by −1 when backwards is set. All addresses wrap modulo 2^22.
- R5: At the end of each row, the destination address becomes the row start plus the destination pitch, and the pixel-in-group counter restarts at 0. In non-pattern modes, the source address becomes its row start plus the source pitch. In pattern modes, the source base is left unchanged.
- R6: Pattern copy reads from one of three addresses, where x is the pixel-in-group counter and y is the row index modulo 8: (src & ~7) + 8·y + x at 8 bpp, (src & ~3) + 16·y + x at 16 bpp, and (src & ~3) + 32·y + x at 32 bpp.
- R7: Monochrome-source expansion tests bit 7−k of the source byte, where k is x, x/2 or x/4 at 8, 16 or 32 bpp. x wraps at 8, 16 or 32. Each time x wraps within a row, the source address advances by one byte.
- R8: Monochrome-pattern expansion reads its mask byte at (src & ~7) | y, where y is the row index modulo 8.
- R9: In both expand modes, the written byte is taken from the foreground colour when the mask bit is 1 and from the background colour when it is 0. The byte lane is 0 at 8 bpp, destination bit 0 at 16 bpp, and destination bits 1:0 at 32 bpp.
- R10: In the expand modes, `mem_wmask` equals the mask bit. In the other modes it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| cfg_width | input | 13 | Bytes per row minus one |
| cfg_height | input | 10 | Rows minus one |
| cfg_src_pitch | input | 13 | Source row pitch in bytes |
| cfg_dst_pitch | input | 13 | Destination row pitch in bytes |
| cfg_src_addr | input | 22 | Source or pattern base address |
| cfg_dst_addr | input | 22 | Destination start address |
| cfg_fg | input | 32 | Foreground colour |
| cfg_bg | input | 32 | Background colour |
| cfg_mode | input | 5 | Pixel width, backwards, pattern, expand |
| mem_addr | output | 22 | Memory byte address |
| mem_we | output | 1 | Write cycle strobe |
| mem_wmask | output | 1 | Byte enable for the write |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the read address |
| done | output | 1 | Operation finished |

## Verification
The assertions assume that the memory returns read data one cycle after the address and that `start` may arrive at any time. They make no assumption about the configuration values. The stimulus keeps the destination region disjoint from the source and pattern regions, so that every source byte the reference model predicts is still unmodified when the engine reads it. Each run also includes a start pulse in the middle of the run with a different destination. The model ignores that pulse, so the cycle-by-cycle comparison catches any attempt by the engine to accept it.

// File: rtl/rect_blit_pkg.sv
// Shared types for the rectangle blitter: mode word layout and pixel widths.
package rect_blit_pkg;

    typedef enum logic [1:0] {
        PIX8  = 2'd0,
        PIX16 = 2'd1,
        PIX32 = 2'd2
    } pix_w_e;

    // Mode word: [4] expand, [3] pattern, [2] backwards, [1:0] pixel width
    typedef struct packed {
        logic       expand;
        logic       pattern;
        logic       backwards;
        logic [1:0] pw;
    } blit_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } blit_state_e;

endpackage

// File: rtl/rect_blit_ctrl.sv
// Sequencer for the rectangle blitter.
// Captures the configuration on start, alternates read and write cycles per
// byte, and keeps the row, column, pixel-in-group and pattern-row counters
// together with the running source and destination addresses.
// Assumes the caller ignores start while busy; this module does so itself.
module rect_blit_ctrl
    import rect_blit_pkg::*;
#(
    parameter int AW = 22,
    parameter int WW = 13,
    parameter int HW = 10,
    parameter int PW = 13,
    parameter int CW = 32,
    parameter int XW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic [PW-1:0] cfg_src_pitch,
    input  logic [PW-1:0] cfg_dst_pitch,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [CW-1:0] cfg_fg,
    input  logic [CW-1:0] cfg_bg,
    input  blit_mode_t    cfg_mode,
    output blit_state_e   state,
    output blit_mode_t    mode_q,
    output logic [AW-1:0] src_cur,
    output logic [AW-1:0] dst_cur,
    output logic [XW-1:0] x_cnt,
    output logic [2:0]    y_row,
    output logic [CW-1:0] fg_q,
    output logic [CW-1:0] bg_q,
    output logic          done
);

    logic [WW-1:0] width_q, col_cnt;
    logic [HW-1:0] height_q, row_cnt;
    logic [PW-1:0] spitch_q, dpitch_q;
    logic [AW-1:0] src_row, dst_row;
    logic [XW-1:0] x_last;
    logic          x_wrap, row_end, last_row;
    logic [AW-1:0] dst_next_row, src_next_row;

    // Last pixel-in-group index for the latched pixel width
    always_comb begin
        case (mode_q.pw)
            PIX16:   x_last = XW'(15);
            PIX32:   x_last = XW'(31);
            default: x_last = XW'(7);
        endcase
    end

    // Row and rectangle end conditions, and next row start addresses
    always_comb begin
        x_wrap       = (x_cnt == x_last);
        row_end      = (col_cnt == width_q);
        last_row     = (row_cnt == height_q);
        dst_next_row = dst_row + AW'(dpitch_q);
        src_next_row = src_row + AW'(spitch_q);
    end

    // Sequencer state, counters and running addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            mode_q   <= '0;
            width_q  <= '0;
            height_q <= '0;
            spitch_q <= '0;
            dpitch_q <= '0;
            fg_q     <= '0;
            bg_q     <= '0;
            src_cur  <= '0;
            src_row  <= '0;
            dst_cur  <= '0;
            dst_row  <= '0;
            col_cnt  <= '0;
            row_cnt  <= '0;
            x_cnt    <= '0;
            y_row    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= cfg_mode;
                        width_q  <= cfg_width;
                        height_q <= cfg_height;
                        spitch_q <= cfg_src_pitch;
                        dpitch_q <= cfg_dst_pitch;
                        fg_q     <= cfg_fg;
                        bg_q     <= cfg_bg;
                        src_cur  <= cfg_src_addr;
                        src_row  <= cfg_src_addr;
                        dst_cur  <= cfg_dst_addr;
                        dst_row  <= cfg_dst_addr;
                        col_cnt  <= '0;
                        row_cnt  <= '0;
                        x_cnt    <= '0;
                        y_row    <= '0;
                        done     <= 1'b0;
                        state    <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    if (row_end) begin
                        if (last_row) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            row_cnt <= row_cnt + 1'b1;
                            y_row   <= y_row + 1'b1;
                            col_cnt <= '0;
                            x_cnt   <= '0;
                            dst_row <= dst_next_row;
                            dst_cur <= dst_next_row;
                            if (!mode_q.pattern) begin
                                src_row <= src_next_row;
                                src_cur <= src_next_row;
                            end
                            state <= ST_RD;
                        end
                    end else begin
                        col_cnt <= col_cnt + 1'b1;
                        x_cnt   <= x_wrap ? '0 : x_cnt + 1'b1;
                        dst_cur <= mode_q.backwards ? dst_cur - 1'b1 : dst_cur + 1'b1;
                        if (!mode_q.pattern && !mode_q.expand)
                            src_cur <= mode_q.backwards ? src_cur - 1'b1 : src_cur + 1'b1;
                        else if (!mode_q.pattern && x_wrap)
                            src_cur <= src_cur + 1'b1;
                        state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rect_blit_srcaddr.sv
// Source address generator: forms the read address for the current byte from
// the running source address, pattern row and pixel-in-group counter.
// Purely combinational; assumes its inputs are stable for the read cycle.
module rect_blit_srcaddr
    import rect_blit_pkg::*;
#(
    parameter int AW = 22,
    parameter int XW = 5
) (
    input  blit_mode_t    mode,
    input  logic [AW-1:0] src_cur,
    input  logic [XW-1:0] x_cnt,
    input  logic [2:0]    y_row,
    output logic [AW-1:0] rd_addr
);

    logic [AW-1:0] base8, base4;

    // Aligned pattern bases
    always_comb begin
        base8 = {src_cur[AW-1:3], 3'b000};
        base4 = {src_cur[AW-1:2], 2'b00};
    end

    // Address selection by source kind and pixel width
    always_comb begin
        case ({mode.expand, mode.pattern})
            2'b01: begin
                case (mode.pw)
                    PIX16:   rd_addr = base4 + (AW'(y_row) << 4) + AW'(x_cnt[3:0]);
                    PIX32:   rd_addr = base4 + (AW'(y_row) << 5) + AW'(x_cnt);
                    default: rd_addr = base8 + (AW'(y_row) << 3) + AW'(x_cnt[2:0]);
                endcase
            end
            2'b11:   rd_addr = base8 | AW'(y_row);
            default: rd_addr = src_cur;
        endcase
    end

endmodule

// File: rtl/rect_blit_pixsel.sv
// Pixel byte selector: in expand modes picks the mask bit from the fetched
// byte and the colour byte lane from the destination address; otherwise
// passes the fetched byte through with a full byte enable.
// Purely combinational; assumes rdata is the byte fetched for this pixel.
module rect_blit_pixsel
    import rect_blit_pkg::*;
#(
    parameter int CW = 32,
    parameter int XW = 5
) (
    input  blit_mode_t    mode,
    input  logic [XW-1:0] x_cnt,
    input  logic [1:0]    dst_lo,
    input  logic [7:0]    rdata,
    input  logic [CW-1:0] fg,
    input  logic [CW-1:0] bg,
    output logic [7:0]    wdata,
    output logic          wmask
);

    logic [2:0]    bit_k;
    logic [1:0]    lane;
    logic          mbit;
    logic [CW-1:0] colour;

    // Bit index and byte lane by pixel width
    always_comb begin
        case (mode.pw)
            PIX16: begin
                bit_k = x_cnt[3:1];
                lane  = {1'b0, dst_lo[0]};
            end
            PIX32: begin
                bit_k = x_cnt[4:2];
                lane  = dst_lo;
            end
            default: begin
                bit_k = x_cnt[2:0];
                lane  = 2'd0;
            end
        endcase
    end

    // Mask bit, colour choice and final byte
    always_comb begin
        mbit   = rdata[3'd7 - bit_k];
        colour = mbit ? fg : bg;
        if (mode.expand) begin
            wdata = colour[8*lane +: 8];
            wmask = mbit;
        end else begin
            wdata = rdata;
            wmask = 1'b1;
        end
    end

endmodule

// File: rtl/rect_blit.sv
// Rectangle pattern and expand blitter, top level.
// Drives a synchronous single-port byte memory: the read cycle presents the
// source address, the write cycle presents the destination byte.
// Assumes mem_rdata is the byte at the address given on the previous cycle.
module rect_blit
    import rect_blit_pkg::*;
#(
    parameter int AW = 22,
    parameter int WW = 13,
    parameter int HW = 10,
    parameter int PW = 13,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WW-1:0] cfg_width,
    input  logic [HW-1:0] cfg_height,
    input  logic [PW-1:0] cfg_src_pitch,
    input  logic [PW-1:0] cfg_dst_pitch,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [CW-1:0] cfg_fg,
    input  logic [CW-1:0] cfg_bg,
    input  logic [4:0]    cfg_mode,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_wmask,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          done
);

    localparam int XW = $clog2(32);

    blit_state_e   state;
    blit_mode_t    mode_q;
    logic [AW-1:0] src_cur, dst_cur, rd_addr;
    logic [XW-1:0] x_cnt;
    logic [2:0]    y_row;
    logic [CW-1:0] fg_q, bg_q;
    logic          expand_q;

    rect_blit_ctrl #(.AW(AW), .WW(WW), .HW(HW), .PW(PW), .CW(CW), .XW(XW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_mode(blit_mode_t'(cfg_mode)),
        .state(state), .mode_q(mode_q), .src_cur(src_cur), .dst_cur(dst_cur),
        .x_cnt(x_cnt), .y_row(y_row), .fg_q(fg_q), .bg_q(bg_q), .done(done)
    );

    rect_blit_srcaddr #(.AW(AW), .XW(XW)) u_srcaddr (
        .mode(mode_q), .src_cur(src_cur), .x_cnt(x_cnt), .y_row(y_row),
        .rd_addr(rd_addr)
    );

    rect_blit_pixsel #(.CW(CW), .XW(XW)) u_pixsel (
        .mode(mode_q), .x_cnt(x_cnt), .dst_lo(dst_cur[1:0]), .rdata(mem_rdata),
        .fg(fg_q), .bg(bg_q), .wdata(mem_wdata), .wmask(mem_wmask)
    );

    // Memory address and strobe by cycle kind
    always_comb begin
        expand_q = mode_q.expand;
        mem_we   = (state == ST_WR);
        case (state)
            ST_RD:   mem_addr = rd_addr;
            ST_WR:   mem_addr = dst_cur;
            default: mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/rect_blit_chk.sv
// Protocol checker for the rectangle blitter, bound to the top level.
module rect_blit_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done,
    input logic mem_we,
    input logic mem_wmask,
    input logic expand_q
);

    // R2: no memory write while the finished flag is up
    a_r2_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    // R2: every write is followed by a read or idle cycle
    a_r2_write_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2: done only rises right after a write cycle
    a_r2_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_we));

    // R2: done only falls when a start was presented
    a_r2_done_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

    // R10: full byte enable outside the expand modes
    a_r10_full_mask_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !expand_q) |-> mem_wmask);

endmodule

bind rect_blit rect_blit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mem_we(mem_we), .mem_wmask(mem_wmask), .expand_q(expand_q)
);

// File: tb/rect_blit_tb.sv
`timescale 1ns/1ps
module rect_blit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] cfg_width = '0;
    logic [9:0]  cfg_height = '0;
    logic [12:0] cfg_src_pitch = '0;
    logic [12:0] cfg_dst_pitch = '0;
    logic [21:0] cfg_src_addr = '0;
    logic [21:0] cfg_dst_addr = '0;
    logic [31:0] cfg_fg = '0;
    logic [31:0] cfg_bg = '0;
    logic [4:0]  cfg_mode = '0;
    logic [21:0] mem_addr;
    logic        mem_we, mem_wmask, done;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem_store [int];

    int          q_addr [$];
    bit          q_we   [$];
    logic [7:0]  q_data [$];
    bit          q_mask [$];

    always #4 clk = ~clk;

    rect_blit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_mode(cfg_mode),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wmask(mem_wmask),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    function automatic logic [7:0] rdf(input int a);
        if (mem_store.exists(a)) return mem_store[a];
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5a);
    endfunction

    // Behavioural memory: registered read, byte write when enabled
    always @(posedge clk) begin
        mem_rdata <= rdf(int'(mem_addr));
        if (mem_we && mem_wmask) mem_store[int'(mem_addr)] = mem_wdata;
    end

    task automatic fail(input string req, input string what, input int act, input int exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    // Build the expected per-cycle stream from the requirements
    task automatic model(input int w, input int h, input int sp, input int dp,
                         input int sa, input int da, input logic [31:0] fg,
                         input logic [31:0] bg, input int mode);
        int pw = mode & 3;
        bit back = mode[2];
        bit pat = mode[3];
        bit exp = mode[4];
        int xmax = (pw == 1) ? 16 : (pw == 2) ? 32 : 8;
        int bpb = (pw == 1) ? 2 : (pw == 2) ? 4 : 1;
        int msk = 32'h3fffff;
        for (int r = 0; r <= h; r++) begin
            int y = r % 8;
            int drow = da + r * dp;
            int srow = pat ? sa : sa + r * sp;
            for (int c = 0; c <= w; c++) begin
                int x = c % xmax;
                int d = (back ? drow - c : drow + c) & msk;
                int s;
                logic [7:0] b, data;
                bit m;
                if (!exp && !pat) s = back ? srow - c : srow + c;
                else if (!exp && pat) begin
                    if (pw == 1) s = (sa & ~3) + y * 16 + x;
                    else if (pw == 2) s = (sa & ~3) + y * 32 + x;
                    else s = (sa & ~7) + y * 8 + x;
                end else if (exp && !pat) s = srow + c / xmax;
                else s = (sa & ~7) | y;
                s = s & msk;
                b = rdf(s);
                if (exp) begin
                    int k = x / bpb;
                    int lane = (pw == 1) ? (d & 1) : (pw == 2) ? (d & 3) : 0;
                    logic [31:0] col;
                    m = b[7 - k];
                    col = m ? fg : bg;
                    data = 8'(col >> (8 * lane));
                end else begin
                    m = 1;
                    data = b;
                end
                q_addr.push_back(s); q_we.push_back(0); q_data.push_back(0); q_mask.push_back(0);
                q_addr.push_back(d); q_we.push_back(1); q_data.push_back(data); q_mask.push_back(m);
            end
        end
    endtask

    task automatic run(input string req, input int w, input int h, input int sp, input int dp,
                       input int sa, input int da, input logic [31:0] fg,
                       input logic [31:0] bg, input int mode, input int intrude);
        q_addr.delete(); q_we.delete(); q_data.delete(); q_mask.delete();
        model(w, h, sp, dp, sa, da, fg, bg, mode);
        @(negedge clk);
        cfg_width = 13'(w); cfg_height = 10'(h);
        cfg_src_pitch = 13'(sp); cfg_dst_pitch = 13'(dp);
        cfg_src_addr = 22'(sa); cfg_dst_addr = 22'(da);
        cfg_fg = fg; cfg_bg = bg; cfg_mode = 5'(mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q_addr.size(); i++) begin
            if (i > 0) @(negedge clk);
            if (i == intrude + 1) start = 1'b0;
            checks++;
            if (done !== 1'b0) fail(req, "done while busy (R2)", int'(done), 0);
            else if (mem_we !== q_we[i]) fail(req, "mem_we", int'(mem_we), int'(q_we[i]));
            else if (mem_addr !== 22'(q_addr[i])) fail(req, "mem_addr", int'(mem_addr), q_addr[i]);
            else if (q_we[i] && mem_wmask !== q_mask[i])
                fail(req, "mem_wmask", int'(mem_wmask), int'(q_mask[i]));
            else if (q_we[i] && mem_wdata !== q_data[i])
                fail(req, "mem_wdata", int'(mem_wdata), int'(q_data[i]));
            if (i == intrude) begin
                // R2: a start while busy with another destination must be ignored
                cfg_dst_addr = cfg_dst_addr ^ 22'h200000;
                start = 1'b1;
            end
        end
        start = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b1 || mem_we !== 1'b0) fail("R2", "done after last write", int'(done), 1);
        repeat (2) @(negedge clk);
        checks++;
        if (done !== 1'b1 || mem_we !== 1'b0) fail("R2", "done holds in idle", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_we !== 1'b0 || mem_addr !== 22'd0)
            fail("R1", "reset state", int'({done, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || mem_we !== 1'b0 || mem_addr !== 22'd0)
            fail("R1", "idle after reset", int'({done, mem_we}), 0);
        // R3/R5: plain copy, forward, three rows, start pulse while busy (R2)
        run("R3", 5, 2, 64, 32, 'h1000, 'h100000, 32'h0, 32'h0, 5'b00000, 4);
        // R4: backwards copy with destination wrapping below zero
        run("R4", 3, 1, 16, 48, 'h2010, 'h000002, 32'h0, 32'h0, 5'b00100, -1);
        // R4: forward destination wrapping past the top of the space
        run("R4", 6, 0, 0, 0, 'h2100, 'h3ffffc, 32'h0, 32'h0, 5'b00000, -1);
        // R6: pattern copy at 8, 16 and 32 bpp, more than eight rows at 8 bpp
        run("R6", 9, 9, 0, 40, 'h3005, 'h110000, 32'h0, 32'h0, 5'b01000, -1);
        run("R6", 17, 2, 0, 64, 'h3106, 'h120000, 32'h0, 32'h0, 5'b01001, -1);
        run("R6", 33, 1, 0, 64, 'h3203, 'h130000, 32'h0, 32'h0, 5'b01010, -1);
        // R7/R9/R10: mono-source expansion at each pixel width
        run("R7", 17, 1, 8, 32, 'h4000, 'h140000, 32'h44332211, 32'hddccbbaa, 5'b10000, -1);
        run("R9", 19, 1, 8, 32, 'h4100, 'h150001, 32'h44332211, 32'hddccbbaa, 5'b10001, -1);
        run("R10", 35, 0, 8, 32, 'h4200, 'h160002, 32'h87654321, 32'h0fedcba9, 5'b10010, -1);
        // R8: mono-pattern expansion over more than eight rows, backwards
        run("R8", 7, 9, 0, 16, 'h5003, 'h170010, 32'h0000a55a, 32'h00003cc3, 5'b11101, -1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule